// File: doc/BRIEF.md
# Interrupt status and mask unit

This block gathers hardware event pulses into a small group of interrupt registers and drives one level-sensitive interrupt line. Each event input sets a sticky status bit. Software clears a status bit by writing one to it. A mask bit set to one hides its source from the interrupt line.

Software never writes the mask directly. It unmasks sources by writing ones to a write-only "unmask" register, and it masks sources by writing ones to a write-only "mask-set" register. In both cases only the bits written as one are touched. Software reads the state back through the status and mask registers.

The register port is 32 bits wide and byte addressed. A write takes effect at the clock edge on which `reg_wr_i` is sampled high. A read is combinational from the current address. The interrupt line is a registered two-state machine:

- `LINE_QUIET` moves to `LINE_RAISED` when some unmasked status bit is set.
- `LINE_RAISED` drops back to `LINE_QUIET` when no unmasked status bit is left.

Top module: `irq_status_mask`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0x1 so that every source starts masked, and `irq_o` is low.
- R2: A high `evt_i` bit at a clock edge sets the matching status bit (bit 0 for the default single source), read back at offset 0x00.
- R3: Writing offset 0x00 clears each status bit whose data bit is 1. A data bit of 0 leaves that status bit unchanged.
- R4: When an event and a one-write to the same status bit arrive at the same edge, the bit ends up set.
- R5: Writing value v to offset 0x08 (unmask) clears the mask bits where v is 1 and keeps the others. Offset 0x08 always reads 0.
- R6: Writing value v to offset 0x0C (mask-set) sets the mask bits where v is 1 and keeps the others. Offset 0x0C always reads 0.
- R7: A direct write to the mask register at offset 0x04 leaves the mask unchanged, whatever the data.
- R8: `irq_o` is 1 exactly when (status AND NOT mask) was nonzero at the previous clock edge. It follows every status, unmask or mask-set change one cycle later.
- R9: Status and mask bits above the number of sources read as 0. Any offset other than 0x00, 0x04, 0x08 and 0x0C reads 0, and writes to such an offset change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr_i | input | ADDR_W (5) | Byte offset of the register accessed |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the register at `reg_addr_i` |
| evt_i | input | NSRC (1) | Event pulses, one per source |
| irq_o | output | 1 | Level interrupt, high while an unmasked status bit is pending |

## Verification
The bench targets several ways the design could go wrong.

- **Event colliding with a clear.** An event landing in the same cycle as a write-one clear must leave the bit set. A design that gave the clear priority would silently lose that event.
- **Zero writes.** Writes of zero to the status register must not clear anything. A design that stored the written value would wipe pending events.
- **Stray mask updates.** The bench writes all-ones and all-zeros straight to the mask register and to unmapped offsets. A decoder that let those through would unmask or mask sources by accident.
- **Line latency.** The interrupt line is sampled in the cycle just after each mask or status change. A combinational line, or one delayed by an extra cycle, shows up as an early or late edge.
- **Random traffic.** A randomised phase mixes all of the above under a reference model that is compared every clock.

// File: rtl/ism_pkg.sv
package ism_pkg;

    localparam int REG_W = 32;

    // Byte offsets of the register group (software contract)
    localparam logic [7:0] OFS_STAT    = 8'h00;
    localparam logic [7:0] OFS_MASK    = 8'h04;
    localparam logic [7:0] OFS_UNMASK  = 8'h08;
    localparam logic [7:0] OFS_MASKSET = 8'h0C;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STAT,
        REG_MASK,
        REG_UNMASK,
        REG_MASKSET
    } reg_id_t;

    typedef struct packed {
        logic stat_clr;
        logic mask_clr;
        logic mask_set;
    } wr_strobe_t;

    typedef enum logic {
        LINE_QUIET,
        LINE_RAISED
    } line_state_t;

endpackage

// File: rtl/ism_decode.sv
module ism_decode
    import ism_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output reg_id_t           reg_id,
    output wr_strobe_t        strb
);

    // Full-address match: anything else is unmapped
    always_comb begin
        reg_id = REG_NONE;
        if (addr == OFS_STAT[ADDR_W-1:0]) begin
            reg_id = REG_STAT;
        end else if (addr == OFS_MASK[ADDR_W-1:0]) begin
            reg_id = REG_MASK;
        end else if (addr == OFS_UNMASK[ADDR_W-1:0]) begin
            reg_id = REG_UNMASK;
        end else if (addr == OFS_MASKSET[ADDR_W-1:0]) begin
            reg_id = REG_MASKSET;
        end
    end

    // Mask register itself has no write strobe: direct writes are dropped
    always_comb begin
        strb = '0;
        if (wr_en) begin
            unique case (reg_id)
                REG_STAT:    strb.stat_clr = 1'b1;
                REG_UNMASK:  strb.mask_clr = 1'b1;
                REG_MASKSET: strb.mask_set = 1'b1;
                default:     strb = '0;
            endcase
        end
    end

endmodule

// File: rtl/ism_status.sv
module ism_status #(
    parameter int NSRC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            clr_stb,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] stat_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic bit_q;

        // Event has priority over the write-one clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (evt[i]) begin
                bit_q <= 1'b1;
            end else if (clr_stb && clr_bits[i]) begin
                bit_q <= 1'b0;
            end
        end

        assign stat_q[i] = bit_q;
    end

endmodule

// File: rtl/ism_mask.sv
module ism_mask #(
    parameter int NSRC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_stb,
    input  logic            set_stb,
    input  logic [NSRC-1:0] bits,
    output logic [NSRC-1:0] mask_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic bit_q;

        // Sources come out of reset masked
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b1;
            end else if (set_stb && bits[i]) begin
                bit_q <= 1'b1;
            end else if (clr_stb && bits[i]) begin
                bit_q <= 1'b0;
            end
        end

        assign mask_q[i] = bit_q;
    end

endmodule

// File: rtl/ism_line.sv
module ism_line
    import ism_pkg::*;
#(
    parameter int NSRC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] stat,
    input  logic [NSRC-1:0] mask,
    output logic            irq_o
);

    line_state_t state_q, state_d;
    logic        pending;

    assign pending = |(stat & ~mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending)  state_d = LINE_RAISED;
            LINE_RAISED: if (!pending) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end

endmodule

// File: rtl/irq_status_mask.sv
module irq_status_mask
    import ism_pkg::*;
#(
    parameter int NSRC   = 1,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [NSRC-1:0]   evt_i,
    output logic              irq_o
);

    reg_id_t         reg_id;
    wr_strobe_t      strb;
    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] mask_q;
    logic            wdata_unused;

    assign wdata_unused = ^reg_wdata_i[REG_W-1:NSRC];

    ism_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .wr_en  (reg_wr_i),
        .addr   (reg_addr_i),
        .reg_id (reg_id),
        .strb   (strb)
    );

    ism_status #(
        .NSRC (NSRC)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .clr_stb  (strb.stat_clr),
        .clr_bits (reg_wdata_i[NSRC-1:0]),
        .stat_q   (stat_q)
    );

    ism_mask #(
        .NSRC (NSRC)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_stb (strb.mask_clr),
        .set_stb (strb.mask_set),
        .bits    (reg_wdata_i[NSRC-1:0]),
        .mask_q  (mask_q)
    );

    ism_line #(
        .NSRC (NSRC)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat_q),
        .mask  (mask_q),
        .irq_o (irq_o)
    );

    // Read mux: strobe registers and unmapped offsets return zero
    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_id)
            REG_STAT: reg_rdata_o[NSRC-1:0] = stat_q;
            REG_MASK: reg_rdata_o[NSRC-1:0] = mask_q;
            default:  reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/ism_checker.sv
module ism_checker
    import ism_pkg::*;
#(
    parameter int NSRC   = 1,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic [31:0]       reg_rdata_o,
    input logic [NSRC-1:0]   evt_i,
    input logic [NSRC-1:0]   stat_q,
    input logic [NSRC-1:0]   mask_q,
    input logic              irq_o
);

    logic at_stat, at_unmask, at_maskset;

    assign at_stat    = (reg_addr_i == OFS_STAT[ADDR_W-1:0]);
    assign at_unmask  = (reg_addr_i == OFS_UNMASK[ADDR_W-1:0]);
    assign at_maskset = (reg_addr_i == OFS_MASKSET[ADDR_W-1:0]);

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[0] |=> stat_q[0]);

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && at_stat && reg_wdata_i[0] && !evt_i[0]) |=> !stat_q[0]);

    p_stat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i[0] && !(reg_wr_i && at_stat && reg_wdata_i[0])) |=> $stable(stat_q[0]));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[0] && reg_wr_i && at_stat && reg_wdata_i[0]) |=> stat_q[0]);

    p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && at_unmask && reg_wdata_i[0]) |=> !mask_q[0]);

    p_unmask_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        at_unmask |-> (reg_rdata_o == 32'h0));

    p_maskset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && at_maskset && reg_wdata_i[0]) |=> mask_q[0]);

    p_maskset_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        at_maskset |-> (reg_rdata_o == 32'h0));

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && (at_unmask || at_maskset)) |=> $stable(mask_q));

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & ~mask_q)) |=> irq_o);

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_q & ~mask_q)) |=> !irq_o);

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (reg_rdata_o[31:NSRC] == '0));

endmodule

bind irq_status_mask ism_checker #(
    .NSRC   (NSRC),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .evt_i       (evt_i),
    .stat_q      (stat_q),
    .mask_q      (mask_q),
    .irq_o       (irq_o)
);

// File: tb/irq_status_mask_bench.sv
`timescale 1ns/1ps
module irq_status_mask_bench;

    localparam int NSRC   = 1;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_STAT    = 5'h00;
    localparam logic [ADDR_W-1:0] A_MASK    = 5'h04;
    localparam logic [ADDR_W-1:0] A_UNMASK  = 5'h08;
    localparam logic [ADDR_W-1:0] A_MASKSET = 5'h0C;
    localparam logic [ADDR_W-1:0] A_HOLE0   = 5'h10;
    localparam logic [ADDR_W-1:0] A_HOLE1   = 5'h14;

    logic              clk   = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr    = 1'b0;
    logic [ADDR_W-1:0] addr  = '0;
    logic [31:0]       wdata = '0;
    logic [NSRC-1:0]   evt   = '0;
    logic [31:0]       rdata;
    logic              irq;

    always #2 clk = ~clk;

    irq_status_mask #(
        .NSRC   (NSRC),
        .ADDR_W (ADDR_W)
    ) u_irq_status_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .evt_i       (evt),
        .irq_o       (irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Behavioural reference state
    bit m_stat = 1'b0;
    bit m_mask = 1'b1;
    bit m_irq  = 1'b0;

    function automatic logic [31:0] m_read(logic [ADDR_W-1:0] a);
        case (a)
            A_STAT:  return {31'b0, m_stat};
            A_MASK:  return {31'b0, m_mask};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [ADDR_W-1:0] a);
        case (a)
            A_STAT:    return "R2/R3/R4";
            A_MASK:    return "R5/R6/R7";
            A_UNMASK:  return "R5";
            A_MASKSET: return "R6";
            default:   return "R9";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
        end
    endtask

    // Model update at each edge, then compare every clock
    always @(posedge clk) begin
        bit pend;
        bit ns;
        bit nm;
        if (!rst_n) begin
            m_stat = 1'b0;
            m_mask = 1'b1;
            m_irq  = 1'b0;
        end else begin
            pend = m_stat & ~m_mask;
            ns = m_stat;
            nm = m_mask;
            if (wr && addr == A_STAT && wdata[0]) ns = 1'b0;
            if (evt[0]) ns = 1'b1;
            if (wr && addr == A_UNMASK && wdata[0]) nm = 1'b0;
            if (wr && addr == A_MASKSET && wdata[0]) nm = 1'b1;
            m_irq  = pend;
            m_stat = ns;
            m_mask = nm;
        end
        #1;
        if (!done) begin
            chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
            chk(tag_of(addr), rdata, m_read(addr));
        end
    end

    task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic wr_reg(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr = 1'b1;
        addr = a;
        wdata = d;
        @(negedge clk);
        wr = 1'b0;
        wdata = '0;
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        evt = 1'b1;
        @(negedge clk);
        evt = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1'b1;
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, 32'h0, "R1");
        rd(A_MASK, 32'h1, "R1");
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 event sets status while masked; line stays low
        pulse_evt();
        rd(A_STAT, 32'h1, "R2");
        @(negedge clk);
        chk("R8 masked", {31'b0, irq}, 32'h0);

        // R5 unmask, line rises one cycle later
        wr_reg(A_UNMASK, 32'h1);
        rd(A_MASK, 32'h0, "R5");
        rd(A_UNMASK, 32'h0, "R5");
        chk("R8 latency", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R8 rise", {31'b0, irq}, 32'h1);

        // R3 zero write keeps, one write clears
        wr_reg(A_STAT, 32'h0);
        rd(A_STAT, 32'h1, "R3");
        wr_reg(A_STAT, 32'h1);
        rd(A_STAT, 32'h0, "R3");
        chk("R8 latency", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R8 fall", {31'b0, irq}, 32'h0);

        // R4 event and clear collide
        @(negedge clk);
        evt = 1'b1;
        wr = 1'b1;
        addr = A_STAT;
        wdata = 32'h1;
        @(negedge clk);
        evt = 1'b0;
        wr = 1'b0;
        wdata = '0;
        rd(A_STAT, 32'h1, "R4");

        // R6 mask-set hides pending source
        wr_reg(A_MASKSET, 32'h1);
        rd(A_MASK, 32'h1, "R6");
        rd(A_MASKSET, 32'h0, "R6");
        @(negedge clk);
        chk("R8 masked fall", {31'b0, irq}, 32'h0);

        // R7 direct mask writes are ignored
        wr_reg(A_MASK, 32'h0);
        rd(A_MASK, 32'h1, "R7");
        wr_reg(A_UNMASK, 32'h1);
        wr_reg(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, 32'h0, "R7");

        // R9 upper bits and unmapped offsets
        wr_reg(A_STAT, 32'hFFFF_FFFF);
        wr_reg(A_HOLE1, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0, "R9");
        rd(A_MASK, 32'h0, "R9");
        pulse_evt();
        rd(A_STAT, 32'h1, "R9");
        rd(A_HOLE0, 32'h0, "R9");
        rd(A_HOLE1, 32'h0, "R9");

        // Random traffic against the reference model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            wr = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 5))
                0: addr = A_STAT;
                1: addr = A_MASK;
                2: addr = A_UNMASK;
                3: addr = A_MASKSET;
                4: addr = A_HOLE0;
                default: addr = A_HOLE1;
            endcase
            wdata = $urandom();
            evt = ($urandom_range(0, 3) == 0);
        end
        @(negedge clk);
        wr = 1'b0;
        evt = 1'b0;
        @(negedge clk);
        done = 1'b1;
        report();
    end

endmodule